// File: doc/BRIEF.md
# Interrupt request capture and dispatch

This block watches a vector of interrupt input pins, keeps one pending bit per pin, and hands pending requests one at a time to a downstream message port. Each pin has a configuration entry supplied by a separate register block. The entry holds a mask bit, a trigger kind (level or edge), a polarity flag, a destination-mode flag, a 3-bit delivery mode, a vector and a destination. The message port uses a valid signal with two responses, accept or refuse. It carries the vector, destination, delivery mode, destination mode, polarity and trigger kind of the pin being served.

A service scan starts when any pending bit newly becomes set, or when the register block pulses its table-write strobe. The scan walks the pins from index 0 upward and stops at each pin that is pending and unmasked. For an entry whose delivery mode is 7, the vector is not taken from the entry. It is fetched from an external legacy interrupt controller through a request/done acknowledge handshake. The block keeps a per-pin delivery-status bit and a count of consecutive refusals. When that count passes five, it raises a stuck flag. An end-of-interrupt input is present and has no effect.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `pending`, `delivery_status`, `msg_valid`, `iack_req` and `stuck` are all 0.
- R2: Each pin passes through two synchronizing flops before the trigger logic. A change on `irq_pin[i]` driven just after a rising edge shows in `pending[i]` after the third rising edge, and not after the second.
- R3: For a pin whose `cfg_level` bit is 1, `pending` follows the synchronized pin level. It is set while the pin is high, cleared when the pin goes low, and an accepted delivery leaves it set.
- R4: For a pin whose `cfg_level` bit is 0, a rising edge of the synchronized level sets `pending`. A falling pin leaves it set, and so does a refused delivery. Only an accepted delivery of that pin clears it.
- R5: A scan starts only when a pending bit goes from 0 to 1 or when `cfg_wr` is pulsed. With no such event, nothing is dispatched, even while a level pin stays pending.
- R6: A scan serves pending, unmasked pins in ascending index order, with at most one message outstanding, and resumes at the next index after accept or refuse.
- R7: A pin whose `cfg_mask` bit is 1 is skipped by the scan and keeps its pending bit.
- R8: When the served entry's delivery mode (3-bit field `cfg_dmode[3*i+2:3*i]`) equals 7, `iack_req` is raised and held until `iack_done`. The message then carries `iack_vector` latched at that cycle. For any other mode, the message carries `cfg_vector[8*i+7:8*i]`.
- R9: While `msg_valid` is high, the message fields hold steady until `msg_accept` or `msg_refuse` (accept wins if both are high). `msg_dest`, `msg_dmode`, `msg_destmode`, `msg_polarity` and `msg_trigger` equal the served pin's `cfg_dest`, `cfg_dmode`, `cfg_destmode`, `cfg_polarity` and `cfg_level` entries.
- R10: A refused delivery sets that pin's `delivery_status` bit, and an accepted delivery clears it.
- R11: Each refusal increments a consecutive-refusal count. `stuck` is 1 once the count exceeds 5, so it rises at the sixth refusal in a row. Any accepted delivery clears the count and `stuck`.
- R12: `eoi_valid` and `eoi_vector` change neither pending bits nor dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | NPINS | Asynchronous interrupt inputs, active high |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger kind, 1 = level, 0 = edge |
| cfg_polarity | input | NPINS | Per-pin polarity flag, forwarded in the message |
| cfg_destmode | input | NPINS | Per-pin destination-mode flag, forwarded |
| cfg_dmode | input | 3*NPINS | Per-pin delivery mode, 3 bits each, 7 = legacy acknowledge |
| cfg_vector | input | VEC_W*NPINS | Per-pin vector |
| cfg_dest | input | DEST_W*NPINS | Per-pin destination |
| cfg_wr | input | 1 | Pulse: table entry was written, request a scan |
| delivery_status | output | NPINS | Per-pin status, 1 after a refusal |
| pending | output | NPINS | Per-pin pending bits |
| msg_valid | output | 1 | Message offered downstream |
| msg_accept | input | 1 | Downstream took the message |
| msg_refuse | input | 1 | Downstream refused the message |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dmode | output | 3 | Message delivery mode |
| msg_destmode | output | 1 | Message destination mode |
| msg_polarity | output | 1 | Message polarity |
| msg_trigger | output | 1 | Message trigger kind, 1 = level |
| iack_req | output | 1 | Vector request to the legacy controller |
| iack_done | input | 1 | Legacy controller returns a vector |
| iack_vector | input | VEC_W | Vector from the legacy controller |
| eoi_valid | input | 1 | End-of-interrupt notice, ignored |
| eoi_vector | input | VEC_W | End-of-interrupt vector, ignored |
| stuck | output | 1 | More than five refusals in a row |

## Verification
The bench goes after the split between trigger kinds. An edge pin must keep its pending bit after the pin falls and after a refusal. A level pin must keep it after an acceptance and drop it when the pin falls. A design that mixed up these rules would lose or repeat interrupts. It also checks the three-edge arrival latency, ascending service order when several pins rise together, skipping of a masked pin that still keeps its pending bit, and that a level pin left pending is not redelivered without a new event. It drives the legacy acknowledge path with a held request and a vector that differs from the table, which catches a design that took the table vector. It checks that `stuck` rises exactly at the sixth consecutive refusal and clears on acceptance, which catches an off-by-one count or a missing counter reset.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_IACK = 2'd2,
        ST_SEND = 2'd3
    } disp_state_e;

    localparam logic [2:0] DM_LEGACY = 3'd7;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o,
    output logic [NPINS-1:0] rise_o
);
    typedef struct packed {
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] s2;
        logic [NPINS-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = pin_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_o  = q.s2;
    assign rise_o = q.s2 & ~q.s3;
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] rise_i,
    input  logic [NPINS-1:0] is_level_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o,
    output logic             set_o
);
    typedef struct packed {
        logic [NPINS-1:0] pend;
    } pend_t;

    pend_t q, d;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            if (is_level_i[i])   d.pend[i] = lvl_i[i];
            else if (rise_i[i])  d.pend[i] = 1'b1;
            else if (clr_i[i])   d.pend[i] = 1'b0;
            else                 d.pend[i] = q.pend[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;
    assign set_o  = |(d.pend & ~q.pend);

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R3: level pins track the synchronized level one cycle later
        a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            is_level_i[g] |=> (pend_o[g] == $past(lvl_i[g])));
        // R4: edge pin stays pending unless cleared by acceptance
        a_r4_edge_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level_i[g] && pend_o[g] && !clr_i[g]) |=> pend_o[g]);
        a_r4_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!is_level_i[g] && rise_i[g]) |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int VEC_W       = 8,
    parameter int DEST_W      = 8,
    parameter int STUCK_LIMIT = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        irq_pin,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic [NPINS-1:0]        cfg_level,
    input  logic [NPINS-1:0]        cfg_polarity,
    input  logic [NPINS-1:0]        cfg_destmode,
    input  logic [3*NPINS-1:0]      cfg_dmode,
    input  logic [VEC_W*NPINS-1:0]  cfg_vector,
    input  logic [DEST_W*NPINS-1:0] cfg_dest,
    input  logic                    cfg_wr,
    output logic [NPINS-1:0]        delivery_status,
    output logic [NPINS-1:0]        pending,
    output logic                    msg_valid,
    input  logic                    msg_accept,
    input  logic                    msg_refuse,
    output logic [VEC_W-1:0]        msg_vector,
    output logic [DEST_W-1:0]       msg_dest,
    output logic [2:0]              msg_dmode,
    output logic                    msg_destmode,
    output logic                    msg_polarity,
    output logic                    msg_trigger,
    output logic                    iack_req,
    input  logic                    iack_done,
    input  logic [VEC_W-1:0]        iack_vector,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    output logic                    stuck
);
    localparam int IDX_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam int FAIL_W = $clog2(STUCK_LIMIT + 2);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NPINS - 1);
    localparam logic [FAIL_W-1:0] FAIL_TOP = FAIL_W'(STUCK_LIMIT + 1);

    typedef struct packed {
        disp_state_e       st;
        logic [IDX_W-1:0]  idx;
        logic [VEC_W-1:0]  vec;
        logic              scan_req;
        logic [NPINS-1:0]  dstat;
        logic [FAIL_W-1:0] fail;
    } disp_t;

    disp_t q, d;

    logic [NPINS-1:0] lvl, rise, clr;
    logic             new_set;
    logic             adv;
    logic [2:0]       cur_dmode;
    logic             unused_eoi;

    // End-of-interrupt is accepted and has no effect (R12)
    assign unused_eoi = eoi_valid | (|eoi_vector);

    irq_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (irq_pin),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    irq_pend #(.NPINS(NPINS)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl),
        .rise_i     (rise),
        .is_level_i (cfg_level),
        .clr_i      (clr),
        .pend_o     (pending),
        .set_o      (new_set)
    );

    assign cur_dmode = cfg_dmode[3*int'(q.idx) +: 3];

    always_comb begin
        d         = q;
        clr       = '0;
        adv       = 1'b0;
        iack_req  = 1'b0;
        msg_valid = 1'b0;
        if (new_set || cfg_wr) d.scan_req = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (q.scan_req) begin
                    d.st       = ST_SCAN;
                    d.idx      = '0;
                    d.scan_req = new_set || cfg_wr;
                end
            end
            ST_SCAN: begin
                if (pending[q.idx] && !cfg_mask[q.idx]) begin
                    if (cur_dmode == DM_LEGACY) begin
                        d.st = ST_IACK;
                    end else begin
                        d.vec = cfg_vector[VEC_W*int'(q.idx) +: VEC_W];
                        d.st  = ST_SEND;
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            ST_IACK: begin
                iack_req = 1'b1;
                if (iack_done) begin
                    d.vec = iack_vector;
                    d.st  = ST_SEND;
                end
            end
            ST_SEND: begin
                msg_valid = 1'b1;
                if (msg_accept) begin
                    d.dstat[q.idx] = 1'b0;
                    clr[q.idx]     = !cfg_level[q.idx];
                    d.fail         = '0;
                    adv            = 1'b1;
                end else if (msg_refuse) begin
                    d.dstat[q.idx] = 1'b1;
                    if (q.fail != FAIL_TOP) d.fail = q.fail + 1'b1;
                    adv            = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (adv) begin
            if (q.idx == LAST_IDX) begin
                d.st = ST_IDLE;
            end else begin
                d.idx = q.idx + 1'b1;
                d.st  = ST_SCAN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign delivery_status = q.dstat;
    assign msg_vector      = q.vec;
    assign msg_dest        = cfg_dest[DEST_W*int'(q.idx) +: DEST_W];
    assign msg_dmode       = cur_dmode;
    assign msg_destmode    = cfg_destmode[q.idx];
    assign msg_polarity    = cfg_polarity[q.idx];
    assign msg_trigger     = cfg_level[q.idx];
    assign stuck           = (q.fail > FAIL_W'(STUCK_LIMIT));

    // R9: an unanswered message stays offered with the same vector
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_accept && !msg_refuse) |=> (msg_valid && $stable(msg_vector)));
    // R7: a masked pin seen by the scan does not lead to a dispatch
    a_r7_masked_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && cfg_mask[q.idx]) |=> (q.st != ST_SEND && q.st != ST_IACK));
    // R8: the legacy request is held until answered
    a_r8_iack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_req && !iack_done) |=> iack_req);
    // R10: a refusal marks the served pin's status
    a_r10_refuse_status: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_refuse && !msg_accept) |=> delivery_status[$past(q.idx)]);
    // R11: acceptance clears the stuck flag
    a_r11_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_accept) |=> !stuck);
    a_r11_stay_stuck: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck && !(msg_valid && msg_accept)) |=> stuck);
endmodule

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
    localparam int N  = 4;
    localparam int VW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    irq_pin, cfg_mask, cfg_level, cfg_polarity, cfg_destmode;
    logic [3*N-1:0]  cfg_dmode;
    logic [VW*N-1:0] cfg_vector;
    logic [DW*N-1:0] cfg_dest;
    logic            cfg_wr, msg_accept, msg_refuse, iack_done, eoi_valid;
    logic [VW-1:0]   iack_vector, eoi_vector, msg_vector;
    logic [DW-1:0]   msg_dest;
    logic [N-1:0]    delivery_status, pending;
    logic            msg_valid, msg_destmode, msg_polarity, msg_trigger, iack_req, stuck;
    logic [2:0]      msg_dmode;

    int n_chk  = 0;
    int n_fail = 0;

    irq_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_polarity(cfg_polarity), .cfg_destmode(cfg_destmode),
        .cfg_dmode(cfg_dmode), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
        .cfg_wr(cfg_wr), .delivery_status(delivery_status), .pending(pending),
        .msg_valid(msg_valid), .msg_accept(msg_accept), .msg_refuse(msg_refuse),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode),
        .msg_destmode(msg_destmode), .msg_polarity(msg_polarity), .msg_trigger(msg_trigger),
        .iack_req(iack_req), .iack_done(iack_done), .iack_vector(iack_vector),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .stuck(stuck)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic waitn(input int n);
        repeat (n) tick();
    endtask

    task automatic rescan;
        cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        repeat (n) begin
            tick();
            if (msg_valid) seen = 1;
        end
        chk(tag, seen, 0);
    endtask

    // Wait for a message for pin p, check it, hold it, then answer it
    task automatic serve(input int p, input int exp_vec, input bit acc, input string tag);
        int w = 0;
        while (!msg_valid && w < 60) begin
            tick();
            w++;
        end
        chk({tag, " valid"}, int'(msg_valid), 1);
        chk({tag, " vector"}, int'(msg_vector), exp_vec);
        chk("R9 dest", int'(msg_dest), int'(cfg_dest[DW*p +: DW]));
        chk("R9 dmode", int'(msg_dmode), int'(cfg_dmode[3*p +: 3]));
        chk("R9 flags", int'({msg_destmode, msg_polarity, msg_trigger}),
            int'({cfg_destmode[p], cfg_polarity[p], cfg_level[p]}));
        waitn(2);
        chk("R9 hold", int'({msg_valid, msg_vector}), int'({1'b1, exp_vec[VW-1:0]}));
        if (acc) msg_accept = 1'b1;
        else     msg_refuse = 1'b1;
        tick();
        msg_accept = 1'b0;
        msg_refuse = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_pin = '0; cfg_mask = '0; cfg_level = '0;
        cfg_polarity = 4'b1010; cfg_destmode = 4'b0110; cfg_dmode = '0;
        for (int i = 0; i < N; i++) begin
            cfg_vector[VW*i +: VW] = VW'(8'h20 + i);
            cfg_dest[DW*i +: DW]   = DW'(8'h40 + 3 * i);
        end
        cfg_wr = 0; msg_accept = 0; msg_refuse = 0; iack_done = 0;
        iack_vector = '0; eoi_valid = 0; eoi_vector = '0;
        waitn(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 reset outputs", int'({pending, delivery_status, msg_valid, iack_req, stuck}), 0);

        // R2 latency and R4 edge pin accepted
        irq_pin[0] = 1'b1;
        waitn(2);
        chk("R2 not before third edge", int'(pending[0]), 0);
        tick();
        chk("R2 arrives on third edge", int'(pending[0]), 1);
        irq_pin[0] = 1'b0;
        serve(0, 8'h20, 1'b1, "R4 edge pin0");
        chk("R4 accepted edge pin cleared", int'(pending[0]), 0);

        // R4 edge pending kept after fall and refusal, R10 status
        irq_pin[1] = 1'b1;
        waitn(3);
        irq_pin[1] = 1'b0;
        waitn(4);
        chk("R4 kept after pin falls", int'(pending[1]), 1);
        serve(1, 8'h21, 1'b0, "R4 refuse pin1");
        chk("R4 kept after refusal", int'(pending[1]), 1);
        chk("R10 status set on refusal", int'(delivery_status[1]), 1);
        rescan();
        serve(1, 8'h21, 1'b1, "R5 rescan pin1");
        chk("R10 status cleared on accept", int'(delivery_status[1]), 0);
        chk("R4 cleared after accept", int'(pending[1]), 0);

        // R3 level pin, R5 no redispatch without event
        cfg_level[2] = 1'b1;
        irq_pin[2] = 1'b1;
        serve(2, 8'h22, 1'b1, "R3 level pin2");
        chk("R3 level stays pending after accept", int'(pending[2]), 1);
        quiet(20, "R5 no redispatch without event");
        rescan();
        serve(2, 8'h22, 1'b1, "R5 table write rescans");
        irq_pin[2] = 1'b0;
        waitn(4);
        chk("R3 level cleared when pin falls", int'(pending[2]), 0);
        cfg_level[2] = 1'b0;
        rescan();
        quiet(20, "R5 empty scan sends nothing");

        // R6 ascending order
        irq_pin = 4'b1011;
        waitn(4);
        irq_pin = '0;
        serve(0, 8'h20, 1'b1, "R6 first pin0");
        serve(1, 8'h21, 1'b1, "R6 second pin1");
        serve(3, 8'h23, 1'b1, "R6 third pin3");
        chk("R6 all served", int'(pending), 0);

        // R7 masked pin skipped and kept
        cfg_mask[1] = 1'b1;
        irq_pin = 4'b0110;
        waitn(4);
        irq_pin = '0;
        serve(2, 8'h22, 1'b1, "R7 masked pin1 skipped");
        chk("R7 masked pin keeps pending", int'(pending[1]), 1);
        cfg_mask[1] = 1'b0;
        rescan();
        serve(1, 8'h21, 1'b1, "R7 unmasked pin1");
        chk("R7 pending drained", int'(pending), 0);

        // R8 legacy acknowledge
        cfg_dmode[2:0] = 3'd7;
        irq_pin[0] = 1'b1;
        waitn(3);
        irq_pin[0] = 1'b0;
        for (int w = 0; w < 60 && !iack_req; w++) tick();
        chk("R8 iack raised", int'({iack_req, msg_valid}), 2);
        waitn(3);
        chk("R8 iack held", int'(iack_req), 1);
        iack_vector = 8'h5A;
        iack_done = 1'b1;
        tick();
        iack_done = 1'b0;
        chk("R8 iack dropped", int'(iack_req), 0);
        serve(0, 8'h5A, 1'b1, "R8 legacy vector");
        cfg_dmode[2:0] = 3'd0;
        cfg_dmode[11:9] = 3'd1;
        irq_pin[3] = 1'b1;
        waitn(3);
        irq_pin[3] = 1'b0;
        serve(3, 8'h23, 1'b1, "R8 own vector mode 1");
        cfg_dmode[11:9] = 3'd0;

        // R11 stuck after six refusals
        irq_pin[1] = 1'b1;
        waitn(3);
        irq_pin[1] = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) rescan();
            serve(1, 8'h21, 1'b0, "R11 refuse");
            chk($sformatf("R11 stuck after %0d refusals", k), int'(stuck), (k > 5) ? 1 : 0);
        end
        rescan();
        serve(1, 8'h21, 1'b1, "R11 accept");
        chk("R11 stuck cleared", int'(stuck), 0);

        // R12 end-of-interrupt ignored
        cfg_mask[0] = 1'b1;
        irq_pin[0] = 1'b1;
        waitn(4);
        irq_pin[0] = 1'b0;
        waitn(2);
        eoi_valid = 1'b1;
        eoi_vector = 8'h20;
        waitn(3);
        eoi_valid = 1'b0;
        chk("R12 eoi leaves pending", int'(pending[0]), 1);
        chk("R12 eoi sends nothing", int'(msg_valid), 0);
        cfg_mask[0] = 1'b0;
        rescan();
        serve(0, 8'h20, 1'b1, "R12 later delivery");
        chk("R12 drained", int'(pending), 0);

        summary();
        $finish;
    end
endmodule